// File: doc/BRIEF.md
# Secure Memory Block-Cipher Sequencer

This block holds two small block RAMs of 64-bit entries. The plaintext side is called red and the ciphertext side is called black. Software loads source blocks through address windows on a 32-bit register bus. It then sets a first block index for each RAM, a block count and an initial vector, and writes a start command. The sequencer walks the run one block at a time. For each block it reads the source RAM, hands a 64-bit word to an external cipher engine over a request/done handshake, and writes the engine's answer into the opposite RAM.

Encryption moves red to black and decryption moves black to red. In chained mode each block is combined with a running 64-bit chaining value that is seeded from the initial vector. Software polls the busy bit or takes the interrupt to learn that the run is over. A zeroize command clears both RAMs one entry per cycle. A start whose run would pass the last RAM entry is refused and flagged.

Register map (byte addresses): 0x000 control, 0x004 count, 0x008 red first index, 0x00C black first index, 0x010 status (read only), 0x014 error flags, 0x018 interrupt control, 0x020 vector low word, 0x024 vector high word. The red window starts at 0x100 and the black window at 0x200. Block k of a RAM sits at window + 8k (low word) and window + 8k + 4 (high word).

Top module: `smseq_top`

## Requirements
- R1: Writing control with bit 2 set while idle starts a run. Status bit 0 (busy) is 1 from the cycle after that write until the last result is written, and status bit 2 (ciphering) is 1 during a run.
- R2: The count register holds the number of blocks minus one. A run issues exactly count + 1 engine requests, and each request stays asserted with a stable word until the engine answers.
- R3: Control bit 0 is the direction. When it is 0, source blocks come from red and results go to black. When it is 1, the reverse holds. The direction is presented on `cph_dec` during the run.
- R4: The first-index registers are block indices. Block k of a run is read from source entry (source first index + k) and written to destination entry (destination first index + k). No other destination entry is changed.
- R5: With control bit 1 clear (no chaining), the engine receives the source block unchanged and its result is stored unchanged.
- R6: Chained encryption: the engine receives source XOR chain, the result is stored, and the result becomes the new chain. The chain starts as {vector high, vector low}.
- R7: Chained decryption: the engine receives the source block, result XOR chain is stored, and the source block becomes the new chain.
- R8: If red first index + count or black first index + count is DEPTH or more, a start sets status bit 12 and error-flag bit 0, and no run or request takes place. Any write to the error-flag register clears the flag.
- R9: The end of a run sets status bit 8 (pending). The `irq` output is pending AND NOT mask, where the mask is interrupt-control bit 0. Writing interrupt-control with bit 1 set clears the pending bit.
- R10: Writing interrupt-control with bit 2 set while idle clears every entry of both RAMs. Busy and status bit 1 (zeroizing) are high for exactly DEPTH cycles.
- R11: Status bit 10 (done) is set at the end of a run and cleared by the next start.
- R12: After reset the status reads 0x0000_0800, with bit 11 (monitor unblocked) a constant 1 and bit 3 a constant 0. `irq` and `cph_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 12 | Register bus byte address |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data (combinational on address) |
| irq | output | 1 | Interrupt: pending and not masked |
| cph_req | output | 1 | Cipher engine request, held until done |
| cph_dec | output | 1 | Direction presented to the engine |
| cph_in | output | 64 | Word handed to the engine |
| cph_done | input | 1 | Engine answer valid for one cycle |
| cph_result | input | 64 | Engine answer |

## Verification
The main function is swept over all four combinations of direction and chaining. Each combination is run at counts of 1, 2, 4, 8 and 16 blocks, with differing red and black first indices, including runs that end exactly at the last entry. The bench engine is a reversible keyed rotation whose latency varies from block to block. Chained and unchained runs therefore give different destination words. A swapped direction shows up as data in the wrong window, and a stray write shows up as a nonzero entry outside the run. A chained encrypt followed by a chained decrypt into a different red location must give back the original plaintext. This separates the two chain-update rules from each other. Out-of-range starts on each RAM, masked and unmasked interrupts, and a zeroize of filled RAMs cover the remaining corners.

// File: rtl/smseq_pkg.sv
package smseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2,
        ST_ZERO = 2'd3
    } seq_st_e;

    localparam logic [11:0] ADR_CTRL  = 12'h000;
    localparam logic [11:0] ADR_LEN   = 12'h004;
    localparam logic [11:0] ADR_RBASE = 12'h008;
    localparam logic [11:0] ADR_BBASE = 12'h00C;
    localparam logic [11:0] ADR_STAT  = 12'h010;
    localparam logic [11:0] ADR_ERR   = 12'h014;
    localparam logic [11:0] ADR_IRQ   = 12'h018;
    localparam logic [11:0] ADR_IVLO  = 12'h020;
    localparam logic [11:0] ADR_IVHI  = 12'h024;
    localparam logic [3:0]  WIN_RED   = 4'h1;
    localparam logic [3:0]  WIN_BLK   = 4'h2;

endpackage

// File: rtl/smseq_ram.sv
module smseq_ram #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [63:0]   wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [63:0]   rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [63:0]   rdata_b
);
    logic [63:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/smseq_chain.sv
module smseq_chain (
    input  logic        cbc,
    input  logic        dec,
    input  logic [63:0] src_blk,
    input  logic [63:0] chain_q,
    input  logic [63:0] result,
    output logic [63:0] eng_in,
    output logic [63:0] dst_blk,
    output logic [63:0] chain_nx
);
    always_comb begin
        if (dec) begin
            eng_in   = src_blk;
            dst_blk  = cbc ? (result ^ chain_q) : result;
            chain_nx = src_blk;
        end else begin
            eng_in   = cbc ? (src_blk ^ chain_q) : src_blk;
            dst_blk  = result;
            chain_nx = result;
        end
    end
endmodule

// File: rtl/smseq_top.sv
module smseq_top
    import smseq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        cph_req,
    output logic        cph_dec,
    output logic [63:0] cph_in,
    input  logic        cph_done,
    input  logic [63:0] cph_result
);
    typedef struct packed {
        seq_st_e       st;
        logic          dec;
        logic          cbc;
        logic          mask;
        logic          pend;
        logic          done;
        logic          lenerr;
        logic [AW-1:0] len;
        logic [AW-1:0] rbase;
        logic [AW-1:0] bbase;
        logic [AW-1:0] off;
        logic [AW-1:0] zidx;
        logic [63:0]   iv;
        logic [63:0]   chain;
    } regs_t;

    regs_t r_q, r_d;

    logic          busy;
    logic          over;
    logic [AW-1:0] src_idx, dst_idx, widx;
    logic          whi;
    logic [1:0]    win_hit;
    logic [63:0]   rd_eng [2];
    logic [63:0]   rd_bus [2];
    logic [63:0]   src_blk, dst_blk, chain_nx;
    logic [31:0]   stat_w;

    assign busy    = (r_q.st != ST_IDLE);
    assign src_idx = (r_q.dec ? r_q.bbase : r_q.rbase) + r_q.off;
    assign dst_idx = (r_q.dec ? r_q.rbase : r_q.bbase) + r_q.off;
    assign widx    = bus_addr[AW+2:3];
    assign whi     = bus_addr[2];
    assign win_hit = {bus_addr[11:8] == WIN_BLK, bus_addr[11:8] == WIN_RED};
    assign over    = (int'(r_q.rbase) + int'(r_q.len) >= DEPTH) ||
                     (int'(r_q.bbase) + int'(r_q.len) >= DEPTH);
    assign src_blk = r_q.dec ? rd_eng[1] : rd_eng[0];

    smseq_chain u_chain (
        .cbc      (r_q.cbc),
        .dec      (r_q.dec),
        .src_blk  (src_blk),
        .chain_q  (r_q.chain),
        .result   (cph_result),
        .eng_in   (cph_in),
        .dst_blk  (dst_blk),
        .chain_nx (chain_nx)
    );

    // Two RAMs: index 0 is red, index 1 is black.
    for (genvar g = 0; g < 2; g++) begin : g_ram
        logic          is_dst;
        logic          we;
        logic [AW-1:0] waddr;
        logic [63:0]   wdata;

        assign is_dst = (g == 0) ? r_q.dec : !r_q.dec;

        always_comb begin
            we    = 1'b0;
            waddr = widx;
            wdata = rd_bus[g];
            if (r_q.st == ST_ZERO) begin
                we    = 1'b1;
                waddr = r_q.zidx;
                wdata = '0;
            end else if (r_q.st == ST_RUN && cph_done && is_dst) begin
                we    = 1'b1;
                waddr = dst_idx;
                wdata = dst_blk;
            end else if (bus_wr && win_hit[g] && !busy) begin
                we = 1'b1;
                if (whi) wdata[63:32] = bus_wdata;
                else     wdata[31:0]  = bus_wdata;
            end
        end

        smseq_ram #(.DEPTH(DEPTH)) u_ram (
            .clk     (clk),
            .we      (we),
            .waddr   (waddr),
            .wdata   (wdata),
            .raddr_a (src_idx),
            .rdata_a (rd_eng[g]),
            .raddr_b (widx),
            .rdata_b (rd_bus[g])
        );
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            unique case (bus_addr)
                ADR_CTRL: if (!busy) begin
                    r_d.dec = bus_wdata[0];
                    r_d.cbc = bus_wdata[1];
                    if (bus_wdata[2]) begin
                        if (over) begin
                            r_d.lenerr = 1'b1;
                        end else begin
                            r_d.st    = ST_RUN;
                            r_d.off   = '0;
                            r_d.chain = r_q.iv;
                            r_d.done  = 1'b0;
                        end
                    end
                end
                ADR_LEN:   if (!busy) r_d.len   = bus_wdata[AW-1:0];
                ADR_RBASE: if (!busy) r_d.rbase = bus_wdata[AW-1:0];
                ADR_BBASE: if (!busy) r_d.bbase = bus_wdata[AW-1:0];
                ADR_IVLO:  if (!busy) r_d.iv[31:0]  = bus_wdata;
                ADR_IVHI:  if (!busy) r_d.iv[63:32] = bus_wdata;
                ADR_ERR:   r_d.lenerr = 1'b0;
                ADR_IRQ: begin
                    r_d.mask = bus_wdata[0];
                    if (bus_wdata[1]) r_d.pend = 1'b0;
                    if (bus_wdata[2] && !busy) begin
                        r_d.st   = ST_ZERO;
                        r_d.zidx = '0;
                    end
                end
                default: ;
            endcase
        end

        unique case (r_q.st)
            ST_RUN: if (cph_done) begin
                r_d.chain = chain_nx;
                if (r_q.off == r_q.len) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.pend = 1'b1;
                end else begin
                    r_d.off = r_q.off + 1'b1;
                    r_d.st  = ST_GAP;
                end
            end
            ST_GAP:  r_d.st = ST_RUN;
            ST_ZERO: begin
                r_d.zidx = r_q.zidx + 1'b1;
                if (r_q.zidx == AW'(DEPTH - 1)) r_d.st = ST_IDLE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        stat_w     = '0;
        stat_w[0]  = busy;
        stat_w[1]  = (r_q.st == ST_ZERO);
        stat_w[2]  = (r_q.st == ST_RUN) || (r_q.st == ST_GAP);
        stat_w[8]  = r_q.pend;
        stat_w[10] = r_q.done;
        stat_w[11] = 1'b1;
        stat_w[12] = r_q.lenerr;
    end

    always_comb begin
        bus_rdata = '0;
        if (win_hit[0]) begin
            bus_rdata = whi ? rd_bus[0][63:32] : rd_bus[0][31:0];
        end else if (win_hit[1]) begin
            bus_rdata = whi ? rd_bus[1][63:32] : rd_bus[1][31:0];
        end else begin
            unique case (bus_addr)
                ADR_CTRL:  bus_rdata = {30'd0, r_q.cbc, r_q.dec};
                ADR_LEN:   bus_rdata = 32'(r_q.len);
                ADR_RBASE: bus_rdata = 32'(r_q.rbase);
                ADR_BBASE: bus_rdata = 32'(r_q.bbase);
                ADR_STAT:  bus_rdata = stat_w;
                ADR_ERR:   bus_rdata = {31'd0, r_q.lenerr};
                ADR_IRQ:   bus_rdata = {31'd0, r_q.mask};
                ADR_IVLO:  bus_rdata = r_q.iv[31:0];
                ADR_IVHI:  bus_rdata = r_q.iv[63:32];
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq     = r_q.pend && !r_q.mask;
    assign cph_req = (r_q.st == ST_RUN);
    assign cph_dec = r_q.dec;
endmodule

// File: rtl/smseq_chk.sv
module smseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] stat,
    input logic        irq,
    input logic        cph_req,
    input logic        cph_done,
    input logic [63:0] cph_in
);
    // R1: requests only while busy
    a_r1_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cph_req |-> stat[0]);

    // R2: a request is held with a stable word until answered
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        cph_req && !cph_done |=> cph_req && $stable(cph_in));

    // R9: interrupt only when pending
    a_r9_irq_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat[8]);

    // R10: zeroizing implies busy and no engine traffic
    a_r10_zero_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stat[1] |-> stat[0] && !cph_req);

    // R8: a refused start never starts ciphering
    a_r8_err_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[12]) |-> !stat[2]);

    // R11: done never shows while ciphering
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stat[10] |-> !stat[2]);
endmodule

bind smseq_top smseq_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat     (stat_w),
    .irq      (irq),
    .cph_req  (cph_req),
    .cph_done (cph_done),
    .cph_in   (cph_in)
);

// File: tb/test_smseq_top.sv
`timescale 1ns/1ps
module test_smseq_top;
    localparam int DEPTH = 16;
    localparam logic [63:0] KEY = 64'h5A3C_96F0_1E2D_4B87;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, cph_req, cph_dec, cph_done;
    logic [63:0] cph_in, cph_result;

    int nchk = 0, nfail = 0, nblk = 0, nreq_tot = 0;
    logic last_dec = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    smseq_top #(.DEPTH(DEPTH)) i_smseq_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .cph_req(cph_req), .cph_dec(cph_dec), .cph_in(cph_in),
        .cph_done(cph_done), .cph_result(cph_result)
    );

    function automatic logic [63:0] enc_f(input logic [63:0] x);
        return {x[55:0], x[63:56]} ^ KEY;
    endfunction
    function automatic logic [63:0] dec_f(input logic [63:0] y);
        logic [63:0] t;
        t = y ^ KEY;
        return {t[7:0], t[63:8]};
    endfunction
    function automatic logic [63:0] pat(input logic [31:0] seed, input int k);
        return {seed ^ (32'h0101_0101 * (k + 1)), ~seed + 32'(k * 7)};
    endfunction

    // engine model with latency 1..3 cycles
    initial begin
        int lat, tgt;
        lat = 0; tgt = 1;
        cph_done = 1'b0; cph_result = '0;
        forever begin
            @(negedge clk);
            cph_done = 1'b0;
            if (cph_req) begin
                lat++;
                if (lat >= tgt) begin
                    cph_result = cph_dec ? dec_f(cph_in) : enc_f(cph_in);
                    cph_done = 1'b1;
                    last_dec = cph_dec;
                    lat = 0;
                    nblk++;
                    nreq_tot++;
                    tgt = 1 + (nreq_tot % 3);
                end
            end else begin
                lat = 0;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic rd64(input logic [11:0] a, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(a, lo);
        rd(a + 12'd4, hi);
        d = {hi, lo};
    endtask

    task automatic wr64(input logic [11:0] a, input logic [63:0] d);
        wr(a, d[31:0]);
        wr(a + 12'd4, d[63:32]);
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] s;
        cyc = 0;
        rd(12'h010, s);
        while (s[0] && cyc < 4000) begin
            cyc++;
            rd(12'h010, s);
        end
    endtask

    task automatic zeroize();
        int c;
        wr(12'h018, 32'h4);
        wait_idle(c);
    endtask

    task automatic run_case(input bit dec, input bit cbc, input int rb, input int bb,
                            input int len, input logic [31:0] seed);
        logic [11:0] sw, dw;
        int sb, db, c;
        logic [31:0] s;
        logic [63:0] iv, ch, x, y, e, got;
        logic [63:0] src [DEPTH];
        sw = dec ? 12'h200 : 12'h100;
        dw = dec ? 12'h100 : 12'h200;
        sb = dec ? bb : rb;
        db = dec ? rb : bb;
        zeroize();
        for (int k = 0; k <= len; k++) begin
            src[k] = pat(seed, k);
            wr64(sw + 12'(8 * (sb + k)), src[k]);
        end
        iv = {~seed, seed ^ 32'hA5A5_0F0F};
        wr(12'h020, iv[31:0]);
        wr(12'h024, iv[63:32]);
        wr(12'h004, 32'(len));
        wr(12'h008, 32'(rb));
        wr(12'h00C, 32'(bb));
        nblk = 0;
        wr(12'h000, {29'd0, 1'b1, cbc, dec});
        rd(12'h010, s);
        check("R1 busy after start", 64'(s[0]), 64'd1);
        check("R11 done cleared by start", 64'(s[10]), 64'd0);
        wait_idle(c);
        check("R2 request count", 64'(nblk), 64'(len + 1));
        check("R3 engine direction", 64'(last_dec), 64'(dec));
        rd(12'h010, s);
        check("R11 status after run", 64'(s), 64'h0000_0D00);
        check("R9 irq unmasked", 64'(irq), 64'd1);
        wr(12'h018, 32'h2);
        check("R9 irq cleared", 64'(irq), 64'd0);
        ch = iv;
        for (int k = 0; k < DEPTH; k++) begin
            rd64(dw + 12'(8 * k), got);
            if (k >= db && k <= db + len) begin
                x = src[k - db];
                if (!dec) begin
                    y = enc_f(cbc ? (x ^ ch) : x);
                    e = y;
                    ch = y;
                end else begin
                    y = dec_f(x);
                    e = cbc ? (y ^ ch) : y;
                    ch = x;
                end
                if (!cbc) check("R5 unchained block", got, e);
                else if (!dec) check("R6 chained encrypt block", got, e);
                else check("R7 chained decrypt block", got, e);
            end else begin
                check("R4 entry outside run untouched", got, 64'd0);
            end
        end
    endtask

    initial begin
        logic [31:0] s;
        logic [63:0] g;
        int c;
        int lens [5] = '{0, 1, 3, 7, 15};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(12'h010, s);
        check("R12 reset status", 64'(s), 64'h800);
        check("R12 reset irq", 64'(irq), 64'd0);
        check("R12 reset request", 64'(cph_req), 64'd0);

        // R10 zeroize of filled RAMs
        for (int k = 0; k < DEPTH; k++) begin
            wr64(12'h100 + 12'(8 * k), pat(32'h1111, k));
            wr64(12'h200 + 12'(8 * k), pat(32'h2222, k));
        end
        wr(12'h018, 32'h4);
        rd(12'h010, s);
        check("R10 zeroizing flag", 64'(s[1:0]), 64'd3);
        wait_idle(c);
        check("R10 zeroize cycles", 64'(c + 1), 64'(DEPTH));
        for (int k = 0; k < DEPTH; k++) begin
            rd64(12'h100 + 12'(8 * k), g);
            check("R10 red cleared", g, 64'd0);
            rd64(12'h200 + 12'(8 * k), g);
            check("R10 black cleared", g, 64'd0);
        end

        // sweep of modes and lengths
        for (int m = 0; m < 4; m++) begin
            for (int li = 0; li < 5; li++) begin
                int len, rb, bb;
                len = lens[li];
                rb = (m * 5 + len) % (DEPTH - len);
                bb = (m * 3 + 2 * len + 1) % (DEPTH - len);
                run_case(m[1], m[0], rb, bb, len, 32'h3C00_0000 + 32'(m * 16 + li));
            end
            run_case(m[1], m[0], DEPTH - 1, DEPTH - 1, 0, 32'h7700 + 32'(m));
            run_case(m[1], m[0], 8, 8, 7, 32'h8800 + 32'(m));
        end

        // round trip: chained encrypt red@2 -> black@7, chained decrypt black@7 -> red@9
        zeroize();
        for (int k = 0; k < 6; k++) wr64(12'h100 + 12'(8 * (2 + k)), pat(32'hBEEF, k));
        wr(12'h020, 32'h0123_4567);
        wr(12'h024, 32'h89AB_CDEF);
        wr(12'h004, 32'd5);
        wr(12'h008, 32'd2);
        wr(12'h00C, 32'd7);
        wr(12'h000, 32'h6);
        wait_idle(c);
        wr(12'h008, 32'd9);
        wr(12'h000, 32'h7);
        wait_idle(c);
        for (int k = 0; k < 6; k++) begin
            rd64(12'h100 + 12'(8 * (9 + k)), g);
            check("R7 round trip recovers plaintext", g, pat(32'hBEEF, k));
        end
        wr(12'h018, 32'h2);

        // R8 length errors on each RAM
        nblk = 0;
        wr(12'h004, 32'd6);
        wr(12'h008, 32'd10);
        wr(12'h00C, 32'd0);
        wr(12'h000, 32'h4);
        repeat (4) @(negedge clk);
        rd(12'h010, s);
        check("R8 red overrun flag and idle", 64'(s & 32'h1005), 64'h1000);
        check("R8 no request on overrun", 64'(nblk), 64'd0);
        wr(12'h014, 32'h0);
        rd(12'h014, s);
        check("R8 error cleared", 64'(s), 64'd0);
        wr(12'h008, 32'd0);
        wr(12'h004, 32'd4);
        wr(12'h00C, 32'd12);
        wr(12'h000, 32'h4);
        repeat (4) @(negedge clk);
        rd(12'h010, s);
        check("R8 black overrun flag", 64'(s & 32'h1005), 64'h1000);
        check("R8 no request on black overrun", 64'(nblk), 64'd0);
        wr(12'h014, 32'h1);
        rd(12'h010, s);
        check("R8 status flag cleared", 64'(s[12]), 64'd0);

        // R9 masked interrupt
        wr(12'h018, 32'h1);
        wr(12'h004, 32'd1);
        wr(12'h00C, 32'd3);
        wr(12'h000, 32'h4);
        wait_idle(c);
        rd(12'h010, s);
        check("R9 pending while masked", 64'(s[8]), 64'd1);
        check("R9 irq masked low", 64'(irq), 64'd0);
        wr(12'h018, 32'h0);
        check("R9 irq after unmask", 64'(irq), 64'd1);
        wr(12'h018, 32'h2);
        rd(12'h010, s);
        check("R9 pending cleared", 64'(s[8]), 64'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule